// File: doc/BRIEF.md
# Region-Based Access Permission Checker

This block looks up every bus access against sixteen programmable address regions and decides whether the access may proceed. Each region holds a base address, a power-of-two size, an eight-bit mask that can exclude any of its eight equal slices, an access-permission code, an execute-never flag and a set of memory-type attribute bits. When regions overlap, the highest-numbered region that matches decides the outcome. An address that no enabled region claims falls to a background rule, which has the lowest priority.

Software programs one region per write through a flat write port. A separate control write turns the whole unit on or off and decides whether the background rule admits privileged accesses. An access presents an address and three qualifiers: write, instruction fetch and privileged. One clock later the block reports whether a region was hit, which region won, its attribute bits, and whether the access faults. A separate flag marks faults caused by fetching from an execute-never region.

Top module: `region_guard`

## Requirements
- R1: Sixteen regions, indexed 0 to 15, are each written whole by one `cfg_we` pulse selecting `cfg_idx`. The new settings apply to every access presented in a later cycle.
- R2: An access presented with `acc_valid` high produces `res_valid` high exactly one cycle later. When `res_valid` is low, `res_hit` and `res_fault` are low.
- R3: When several enabled regions contain the address, the highest index wins. `res_region` carries that index and `res_tex`/`res_c`/`res_b`/`res_s` carry its attributes. On a miss, `res_region` and all attributes are 0.
- R4: The region size is 2^`cfg_size` bytes. Codes below 8 are treated as 8 (256 bytes), and codes above 31 are treated as 31. Base-address bits below the size are ignored, so every region is aligned to its size.
- R5: The region splits into eight equal slices, with slice k covering offsets k·size/8 to (k+1)·size/8−1. Bit k of `cfg_srd` set to 1 removes slice k from the region. An address in a removed slice falls through to the next lower matching region, or to the background rule.
- R6: A region written with `cfg_en`=0 never matches.
- R7: In a region written with `cfg_xn`=1, an instruction fetch (`acc_fetch`=1) that hits the region faults and raises `res_xn_fault`. With `cfg_xn`=0, fetches are judged only by the permission code.
- R8: The permission codes (`cfg_ap`, a fetch counts as a read) are:
  - 0: no access.
  - 1: privileged read/write, no user access.
  - 2: privileged read/write, user read only.
  - 3: full access.
  - 4: reserved, no access.
  - 5: privileged read only.
  - 6 and 7: read only for all.
  
  A denied access raises `res_fault`.
- R9: With the unit enabled, a miss faults unless `ctl_bg_en`=1 and the access is privileged.
- R10: While the unit is disabled, no access faults, `res_hit` is 0 and all attributes are 0.
- R11: Reset disables the unit and all sixteen regions, and clears `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one region's settings |
| cfg_idx | input | 4 | Region index to write |
| cfg_en | input | 1 | Region enable |
| cfg_base | input | 32 | Region base address |
| cfg_size | input | 5 | Region size as log2 of bytes |
| cfg_srd | input | 8 | Slice removal mask |
| cfg_ap | input | 3 | Access permission code |
| cfg_xn | input | 1 | Execute-never |
| cfg_tex | input | 3 | Type-extension attribute bits |
| cfg_c | input | 1 | Cacheable attribute |
| cfg_b | input | 1 | Bufferable attribute |
| cfg_s | input | 1 | Shareable attribute |
| ctl_we | input | 1 | Write global control |
| ctl_unit_en | input | 1 | Unit enable |
| ctl_bg_en | input | 1 | Background admits privileged accesses |
| acc_valid | input | 1 | Access present |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_priv | input | 1 | Access is privileged |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | An enabled region matched |
| res_region | output | 4 | Winning region index |
| res_fault | output | 1 | Access denied |
| res_xn_fault | output | 1 | Denied as fetch from execute-never region |
| res_tex | output | 3 | Winning type-extension bits |
| res_c | output | 1 | Winning cacheable bit |
| res_b | output | 1 | Winning bufferable bit |
| res_s | output | 1 | Winning shareable bit |

## Verification
The checker watches a set of properties on every cycle:
- the one-cycle result lag;
- quiet outputs between results;
- no hit, no fault and zeroed attributes while the unit is off;
- execute-never faults only on fetches that hit a region;
- unprivileged misses always faulting.

Other behaviour depends on what was programmed, so only the bench's scenarios can show it:
- which of several overlapping regions wins;
- falling through a removed slice to a lower region;
- a disabled region being skipped;
- size clamping and ignoring of base bits below the size;
- each permission code against each kind of access;
- a reprogrammed region taking effect on the very next access.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

   typedef enum logic [2:0] {
      AP_NONE     = 3'd0,
      AP_PRIV_RW  = 3'd1,
      AP_USER_RO  = 3'd2,
      AP_FULL     = 3'd3,
      AP_RSVD     = 3'd4,
      AP_PRIV_RO  = 3'd5,
      AP_ALL_RO   = 3'd6,
      AP_ALL_RO2  = 3'd7
   } ap_e;

   typedef struct packed {
      logic [2:0] tex;
      logic       c;
      logic       b;
      logic       s;
   } attr_t;

   localparam int ATTR_W = $bits(attr_t);

   function automatic logic ap_allows(input ap_e ap, input logic priv, input logic wr);
      logic ok;
      case (ap)
         AP_PRIV_RW: ok = priv;
         AP_USER_RO: ok = priv || !wr;
         AP_FULL:    ok = 1'b1;
         AP_PRIV_RO: ok = priv && !wr;
         AP_ALL_RO,
         AP_ALL_RO2: ok = !wr;
         default:    ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/rg_region.sv
module rg_region
   import region_guard_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int MIN_LOG2 = 8,
   parameter int SUBS     = 8,
   localparam int SIZE_W  = $clog2(ADDR_W),
   localparam int SUB_W   = $clog2(SUBS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              w_en,
   input  logic [ADDR_W-1:0] w_base,
   input  logic [SIZE_W-1:0] w_size,
   input  logic [SUBS-1:0]   w_srd,
   input  logic [2:0]        w_ap,
   input  logic              w_xn,
   input  attr_t             w_attr,
   input  logic [ADDR_W-1:0] addr,
   output logic              match,
   output logic [2:0]        ap,
   output logic              xn,
   output attr_t             attr
);

   localparam logic [SIZE_W-1:0] SZ_MIN = SIZE_W'(MIN_LOG2);
   localparam logic [SIZE_W-1:0] SZ_MAX = SIZE_W'(ADDR_W - 1);

   logic              en_q;
   logic [ADDR_W-1:0] base_q;
   logic [SIZE_W-1:0] size_q;
   logic [SUBS-1:0]   srd_q;
   logic [SIZE_W-1:0] size_clamped;

   always_comb begin
      if (w_size < SZ_MIN)      size_clamped = SZ_MIN;
      else if (w_size > SZ_MAX) size_clamped = SZ_MAX;
      else                      size_clamped = w_size;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         base_q <= '0;
         size_q <= SZ_MIN;
         srd_q  <= '0;
         ap     <= 3'd0;
         xn     <= 1'b0;
         attr   <= '0;
      end else if (we) begin
         en_q   <= w_en;
         base_q <= w_base;
         size_q <= size_clamped;
         srd_q  <= w_srd;
         ap     <= w_ap;
         xn     <= w_xn;
         attr   <= w_attr;
      end
   end

   logic [ADDR_W-1:0] hi_mask;
   logic [ADDR_W-1:0] sub_shift;
   logic [SUB_W-1:0]  sub_idx;
   logic              in_range;

   always_comb begin
      hi_mask   = {ADDR_W{1'b1}} << size_q;
      in_range  = ((addr ^ base_q) & hi_mask) == '0;
      sub_shift = addr >> (size_q - SIZE_W'(SUB_W));
      sub_idx   = sub_shift[SUB_W-1:0];
      match     = en_q && in_range && !srd_q[sub_idx];
   end

endmodule

// File: rtl/rg_resolve.sv
module rg_resolve
   import region_guard_pkg::*;
#(
   parameter int N      = 16,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]        match,
   input  logic [N-1:0][2:0]   ap_v,
   input  logic [N-1:0]        xn_v,
   input  attr_t [N-1:0]       attr_v,
   output logic                hit,
   output logic [IDX_W-1:0]    idx,
   output logic [2:0]          ap,
   output logic                xn,
   output attr_t               attr
);

   always_comb begin
      hit  = 1'b0;
      idx  = '0;
      ap   = 3'd0;
      xn   = 1'b0;
      attr = '0;
      for (int i = 0; i < N; i++) begin
         if (match[i]) begin
            hit  = 1'b1;
            idx  = IDX_W'(i);
            ap   = ap_v[i];
            xn   = xn_v[i];
            attr = attr_v[i];
         end
      end
   end

endmodule

// File: rtl/region_guard.sv
module region_guard
   import region_guard_pkg::*;
#(
   parameter int N_REGIONS = 16,
   parameter int ADDR_W    = 32,
   parameter int MIN_LOG2  = 8,
   localparam int IDX_W    = $clog2(N_REGIONS),
   localparam int SIZE_W   = $clog2(ADDR_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic              cfg_en,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [SIZE_W-1:0] cfg_size,
   input  logic [7:0]        cfg_srd,
   input  logic [2:0]        cfg_ap,
   input  logic              cfg_xn,
   input  logic [2:0]        cfg_tex,
   input  logic              cfg_c,
   input  logic              cfg_b,
   input  logic              cfg_s,
   input  logic              ctl_we,
   input  logic              ctl_unit_en,
   input  logic              ctl_bg_en,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   input  logic              acc_fetch,
   input  logic              acc_priv,
   output logic              res_valid,
   output logic              res_hit,
   output logic [IDX_W-1:0]  res_region,
   output logic              res_fault,
   output logic              res_xn_fault,
   output logic [2:0]        res_tex,
   output logic              res_c,
   output logic              res_b,
   output logic              res_s
);

   generate
      if (N_REGIONS < 2 || (N_REGIONS & (N_REGIONS - 1)) != 0) begin : g_bad_n
         $error("N_REGIONS must be a power of two of at least 2");
      end
      if (MIN_LOG2 < 3 || MIN_LOG2 >= ADDR_W) begin : g_bad_min
         $error("MIN_LOG2 must lie in 3 .. ADDR_W-1");
      end
      if ((ADDR_W & (ADDR_W - 1)) != 0) begin : g_bad_addr
         $error("ADDR_W must be a power of two");
      end
   endgenerate

   logic unit_en_q;
   logic bg_en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         unit_en_q <= 1'b0;
         bg_en_q   <= 1'b0;
      end else if (ctl_we) begin
         unit_en_q <= ctl_unit_en;
         bg_en_q   <= ctl_bg_en;
      end
   end

   attr_t w_attr;
   assign w_attr = '{tex: cfg_tex, c: cfg_c, b: cfg_b, s: cfg_s};

   logic [N_REGIONS-1:0]      match_v;
   logic [N_REGIONS-1:0][2:0] ap_v;
   logic [N_REGIONS-1:0]      xn_v;
   attr_t [N_REGIONS-1:0]     attr_v;

   for (genvar g = 0; g < N_REGIONS; g++) begin : g_region
      rg_region #(
         .ADDR_W   (ADDR_W),
         .MIN_LOG2 (MIN_LOG2),
         .SUBS     (8)
      ) u_region (
         .clk    (clk),
         .rst_n  (rst_n),
         .we     (cfg_we && (cfg_idx == IDX_W'(g))),
         .w_en   (cfg_en),
         .w_base (cfg_base),
         .w_size (cfg_size),
         .w_srd  (cfg_srd),
         .w_ap   (cfg_ap),
         .w_xn   (cfg_xn),
         .w_attr (w_attr),
         .addr   (acc_addr),
         .match  (match_v[g]),
         .ap     (ap_v[g]),
         .xn     (xn_v[g]),
         .attr   (attr_v[g])
      );
   end

   logic             win_hit;
   logic [IDX_W-1:0] win_idx;
   logic [2:0]       win_ap;
   logic             win_xn;
   attr_t            win_attr;

   rg_resolve #(.N(N_REGIONS)) u_resolve (
      .match  (match_v),
      .ap_v   (ap_v),
      .xn_v   (xn_v),
      .attr_v (attr_v),
      .hit    (win_hit),
      .idx    (win_idx),
      .ap     (win_ap),
      .xn     (win_xn),
      .attr   (win_attr)
   );

   logic             nx_hit;
   logic [IDX_W-1:0] nx_idx;
   logic             nx_fault;
   logic             nx_xnf;
   attr_t            nx_attr;

   always_comb begin
      nx_hit   = 1'b0;
      nx_idx   = '0;
      nx_fault = 1'b0;
      nx_xnf   = 1'b0;
      nx_attr  = '0;
      if (unit_en_q) begin
         if (win_hit) begin
            nx_hit   = 1'b1;
            nx_idx   = win_idx;
            nx_attr  = win_attr;
            nx_xnf   = acc_fetch && win_xn;
            nx_fault = nx_xnf || !ap_allows(ap_e'(win_ap), acc_priv, acc_write);
         end else begin
            nx_fault = !(bg_en_q && acc_priv);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid    <= 1'b0;
         res_hit      <= 1'b0;
         res_region   <= '0;
         res_fault    <= 1'b0;
         res_xn_fault <= 1'b0;
         res_tex      <= 3'd0;
         res_c        <= 1'b0;
         res_b        <= 1'b0;
         res_s        <= 1'b0;
      end else begin
         res_valid    <= acc_valid;
         res_hit      <= acc_valid && nx_hit;
         res_region   <= acc_valid ? nx_idx : '0;
         res_fault    <= acc_valid && nx_fault;
         res_xn_fault <= acc_valid && nx_xnf;
         res_tex      <= acc_valid ? nx_attr.tex : 3'd0;
         res_c        <= acc_valid && nx_attr.c;
         res_b        <= acc_valid && nx_attr.b;
         res_s        <= acc_valid && nx_attr.s;
      end
   end

endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       unit_en_q,
   input logic       acc_valid,
   input logic       acc_fetch,
   input logic       acc_priv,
   input logic       res_valid,
   input logic       res_hit,
   input logic       res_fault,
   input logic       res_xn_fault,
   input logic [2:0] res_tex,
   input logic       res_c,
   input logic       res_b,
   input logic       res_s
);

   p_result_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid == $past(acc_valid));

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (!res_fault && !res_hit && !res_xn_fault));

   p_off_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(acc_valid) && !$past(unit_en_q)) |->
         (!res_fault && !res_hit && res_tex == 3'd0 && !res_c && !res_b && !res_s));

   p_xn_on_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      res_xn_fault |-> ($past(acc_fetch) && res_fault && res_hit));

   p_user_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit && $past(unit_en_q) && !$past(acc_priv)) |-> res_fault);

endmodule

bind region_guard region_guard_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .unit_en_q    (unit_en_q),
   .acc_valid    (acc_valid),
   .acc_fetch    (acc_fetch),
   .acc_priv     (acc_priv),
   .res_valid    (res_valid),
   .res_hit      (res_hit),
   .res_fault    (res_fault),
   .res_xn_fault (res_xn_fault),
   .res_tex      (res_tex),
   .res_c        (res_c),
   .res_b        (res_b),
   .res_s        (res_s)
);

// File: tb/tb_region_guard.sv
module tb_region_guard;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_idx = '0;
   logic        cfg_en = 1'b0;
   logic [31:0] cfg_base = '0;
   logic [4:0]  cfg_size = '0;
   logic [7:0]  cfg_srd = '0;
   logic [2:0]  cfg_ap = '0;
   logic        cfg_xn = 1'b0;
   logic [2:0]  cfg_tex = '0;
   logic        cfg_c = 1'b0, cfg_b = 1'b0, cfg_s = 1'b0;
   logic        ctl_we = 1'b0, ctl_unit_en = 1'b0, ctl_bg_en = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_write = 1'b0, acc_fetch = 1'b0, acc_priv = 1'b0;
   logic        res_valid, res_hit, res_fault, res_xn_fault;
   logic [3:0]  res_region;
   logic [2:0]  res_tex;
   logic        res_c, res_b, res_s;

   always #5 clk = ~clk;

   region_guard dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_base(cfg_base),
      .cfg_size(cfg_size), .cfg_srd(cfg_srd), .cfg_ap(cfg_ap), .cfg_xn(cfg_xn),
      .cfg_tex(cfg_tex), .cfg_c(cfg_c), .cfg_b(cfg_b), .cfg_s(cfg_s),
      .ctl_we(ctl_we), .ctl_unit_en(ctl_unit_en), .ctl_bg_en(ctl_bg_en),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
      .acc_fetch(acc_fetch), .acc_priv(acc_priv),
      .res_valid(res_valid), .res_hit(res_hit), .res_region(res_region),
      .res_fault(res_fault), .res_xn_fault(res_xn_fault),
      .res_tex(res_tex), .res_c(res_c), .res_b(res_b), .res_s(res_s)
   );

   // packed vector: addr, write, fetch, priv | hit, region, fault, xn, attr{tex,c,b,s}
   typedef struct packed {
      logic [31:0] addr;
      logic        wr;
      logic        fe;
      logic        pr;
      logic        hit;
      logic [3:0]  rgn;
      logic        fault;
      logic        xn;
      logic [5:0]  attr;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      {32'h6000_1000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3,  1'b0, 1'b0, 6'h0F}, // R3 overlap, R8 RO read
      {32'h6000_1000, 1'b1, 1'b0, 1'b1, 1'b1, 4'd3,  1'b1, 1'b0, 6'h0F}, // R8 write to RO
      {32'h6000_1000, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3,  1'b1, 1'b1, 6'h0F}, // R7 fetch XN
      {32'h6000_4010, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0,  1'b0, 1'b0, 6'h02}, // R5 slice fall-through
      {32'h6001_0000, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0,  1'b0, 1'b0, 6'h02}, // R7 fetch allowed
      {32'h6000_0010, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3,  1'b0, 1'b0, 6'h0F}, // R6 disabled region skipped
      {32'h2000_0010, 1'b0, 1'b0, 1'b1, 1'b1, 4'd9,  1'b0, 1'b0, 6'h11}, // R8 priv RW ok
      {32'h2000_0010, 1'b0, 1'b0, 1'b0, 1'b1, 4'd9,  1'b1, 1'b0, 6'h11}, // R8 user denied
      {32'h2000_0850, 1'b0, 1'b0, 1'b1, 1'b1, 4'd15, 1'b1, 1'b0, 6'h00}, // R4 base low bits, R8 none
      {32'h3000_00F0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd12, 1'b0, 1'b0, 6'h00}, // R4 size clamp
      {32'h3000_0100, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 6'h00}, // R9 user miss
      {32'h3000_0100, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  1'b0, 1'b0, 6'h00}, // R9 priv miss bg on
      {32'h2000_0900, 1'b1, 1'b0, 1'b1, 1'b1, 4'd9,  1'b0, 1'b0, 6'h11}  // R3 lower region outside top
   };
   localparam string TAG [NV] = '{"R3", "R8", "R7", "R5", "R7", "R6", "R8", "R8",
                                  "R4", "R4", "R9", "R9", "R3"};

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic prog(input logic [3:0] idx, input logic en, input logic [31:0] base,
                       input logic [4:0] sz, input logic [7:0] srd, input logic [2:0] ap,
                       input logic xn, input logic [5:0] attr);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = idx; cfg_en = en; cfg_base = base; cfg_size = sz;
      cfg_srd = srd; cfg_ap = ap; cfg_xn = xn;
      {cfg_tex, cfg_c, cfg_b, cfg_s} = attr;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic ctl(input logic en, input logic bg);
      @(negedge clk);
      ctl_we = 1'b1; ctl_unit_en = en; ctl_bg_en = bg;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   // drive at a falling edge, result registered at the next rising edge, sampled at the falling edge after
   task automatic access(input logic [31:0] a, input logic wr, input logic fe, input logic pr);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_write = wr; acc_fetch = fe; acc_priv = pr;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   function automatic logic [31:0] outv();
      return {19'd0, res_hit, res_region, res_fault, res_xn_fault, res_tex, res_c, res_b, res_s};
   endfunction

   function automatic logic [31:0] expv(input vec_t v);
      return {19'd0, v.hit, v.rgn, v.fault, v.xn, v.attr};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      check("R11 valid after reset", {31'd0, res_valid}, 32'd0);
      access(32'h6000_1000, 1'b1, 1'b0, 1'b0);
      check("R11 unit off after reset", {29'd0, res_valid, res_hit, res_fault}, 32'b100);

      prog(4'd0,  1'b1, 32'h6000_0000, 5'd28, 8'h00, 3'd3, 1'b0, 6'h02);
      prog(4'd3,  1'b1, 32'h6000_0000, 5'd16, 8'h04, 3'd6, 1'b1, 6'h0F);
      prog(4'd7,  1'b0, 32'h6000_0000, 5'd12, 8'h00, 3'd0, 1'b0, 6'h3F);
      prog(4'd9,  1'b1, 32'h2000_0000, 5'd12, 8'h00, 3'd1, 1'b0, 6'h11);
      prog(4'd12, 1'b1, 32'h3000_0000, 5'd3,  8'h00, 3'd3, 1'b0, 6'h00);
      prog(4'd15, 1'b1, 32'h2000_08FF, 5'd8,  8'h00, 3'd0, 1'b0, 6'h00);
      ctl(1'b1, 1'b1);

      for (int i = 0; i < NV; i++) begin
         access(VEC[i].addr, VEC[i].wr, VEC[i].fe, VEC[i].pr);
         check(TAG[i], outv(), expv(VEC[i]));
      end

      // R2 idle cycle: no result
      @(negedge clk);
      check("R2 idle", {30'd0, res_valid, res_fault}, 32'd0);

      // R1 reprogram takes effect on the next access
      prog(4'd15, 1'b1, 32'h2000_0800, 5'd8, 8'h00, 3'd3, 1'b0, 6'h01);
      access(32'h2000_0850, 1'b1, 1'b0, 1'b0);
      check("R1 rewrite", outv(), {19'd0, 1'b1, 4'd15, 1'b0, 1'b0, 6'h01});

      // R8 privileged read-only code
      prog(4'd9, 1'b1, 32'h2000_0000, 5'd12, 8'h00, 3'd5, 1'b0, 6'h11);
      access(32'h2000_0010, 1'b1, 1'b0, 1'b1);
      check("R8 priv RO write", {31'd0, res_fault}, 32'd1);
      access(32'h2000_0010, 1'b0, 1'b0, 1'b1);
      check("R8 priv RO read", {31'd0, res_fault}, 32'd0);

      // R9 background off: privileged miss faults
      ctl(1'b1, 1'b0);
      access(32'h3000_0100, 1'b0, 1'b0, 1'b1);
      check("R9 bg off", {30'd0, res_hit, res_fault}, 32'b01);

      // R10 unit off: a normally faulting access passes with zero attributes
      ctl(1'b0, 1'b0);
      access(32'h6000_1000, 1'b1, 1'b1, 1'b0);
      check("R10 unit off", outv(), 32'd0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule